// File: doc/BRIEF.md
# Fixed-Frequency Boost PWM Gate Generator

This block produces the switch-on command for each cycle of a boost converter that runs average-current control at a fixed switching rate. A period counter clocked from the system clock defines every switching cycle. Each cycle opens with a forced blanking interval in which the gate is held low, both control latches are cleared and the digital ramp is held at zero. After that interval the ramp count runs, and the gate turns on as soon as the external ramp-crossing comparator reports a crossing. From then on it stays on until the cycle ends.

A peak-current comparator input goes through a consecutive-sample filter. Once accepted, it sets a limit latch that keeps the gate off for the rest of the cycle. A fault input masks the gate at once. A duty-reduce input makes the block ignore crossings that come before a set point in the period, which shortens the on-time. All intervals are given in nanoseconds or hertz and turned into clock counts at elaboration.

Top module: `boost_pwm_gate`

## Requirements
- R1: While rst_ni is low, gate_o is 0 and ramp_o is 0, whatever the other inputs are.
- R2: The period is floor(CLK_HZ/SW_HZ) clocks. The phase starts at 0 after reset and wraps to 0 after PERIOD-1.
- R3: The blanking interval covers phases 0 to TOFF-1, with TOFF = ceil(TOFF_NS*CLK_HZ/1e9). In it gate_o is 0 and ramp_o is 0 whatever the inputs are, and a crossing or accepted peak seen only in this interval has no effect later in the cycle.
- R4: Outside blanking, ramp_o equals phase minus TOFF and so rises by one per clock.
- R5: Outside blanking, gate_o goes high in the same clock in which cross_i is high and stays high until the period ends, even if cross_i falls, unless R7, R9 or R10 intervene.
- R6: With cross_i held high, gate_o is high for exactly PERIOD-TOFF clocks per period.
- R7: peak_i is accepted once it has been sampled high on DG consecutive clock edges, with DG = ceil(DEGLITCH_NS*CLK_HZ/1e9). From the next clock, gate_o is 0 until the period ends. The next period starts with the limit cleared.
- R8: A peak_i pulse shorter than DG samples does not change gate_o.
- R9: fault_i high forces gate_o to 0 in the same clock. It does not clear the on state, so the gate comes back when fault_i falls within the same period.
- R10: While reduce_i is high, a crossing at a phase below RED_AT = floor(PERIOD*REDUCE_PCT/100) is ignored. A crossing held high turns the gate on at phase RED_AT, which gives PERIOD-RED_AT on clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cross_i | input | 1 | Ramp-crossing comparator result, high to turn on |
| peak_i | input | 1 | Peak-current comparator result, before filtering |
| fault_i | input | 1 | Global fault, masks the gate |
| reduce_i | input | 1 | Duty-reduce request |
| gate_o | output | 1 | Gate-on command |
| ramp_o | output | CntW | Released ramp count, 0 during blanking |

## Verification
A held-high crossing measures the maximum duty and tells whether blanking is counted correctly. A late rising crossing that drops again shows whether the on state is latched or just follows the comparator. A crossing that lies only inside blanking shows whether the clear takes priority over a set. Peak pulses one sample short of the filter length and exactly at it show where acceptance happens. A fault pulse in the middle of the on-time shows whether fault masks or clears. Early crossings under reduce show the on-time cap. Randomly mixed periods then exercise all of these inputs together against a per-clock expected model.

// File: rtl/pwm_cfg_pkg.sv
package pwm_cfg_pkg;
  function automatic int ns_to_cyc(longint ns, longint hz);
    return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int PERIOD = 400,
  parameter int TOFF   = 50,
  parameter int CNT_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             minoff_o,
  output logic [CNT_W-1:0] ramp_o
);
  localparam logic [CNT_W-1:0] LastPh = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ToffPh = CNT_W'(TOFF);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == LastPh) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign minoff_o = (cnt_q < ToffPh);
  assign ramp_o   = minoff_o ? '0 : cnt_q - ToffPh;

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LastPh) |=> (cnt_q == '0));
  a_r4_ramp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!minoff_o && cnt_q != LastPh) |=> (ramp_o == $past(ramp_o) + 1'b1));
endmodule

// File: rtl/pwm_deglitch.sv
module pwm_deglitch #(
  parameter int DG = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic peak_i,
  output logic acc_o
);
  localparam int RunW = $clog2(DG + 1);
  localparam logic [RunW-1:0] Full = RunW'(DG);

  logic [RunW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!peak_i)     run_q <= '0;
    else if (run_q != Full) run_q <= run_q + 1'b1;
  end

  assign acc_o = (run_q == Full);

  // acceptance only ever follows a high sample
  a_r8_no_short_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_o) |-> $past(peak_i));
endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl #(
  parameter int CNT_W  = 9,
  parameter int RED_AT = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             minoff_i,
  input  logic             cross_i,
  input  logic             reduce_i,
  input  logic             pk_i,
  input  logic             fault_i,
  output logic             on_o,
  output logic             gate_o
);
  localparam logic [CNT_W-1:0] RedPh = CNT_W'(RED_AT);

  logic on_q, lim_q, set_on, lim_now;

  // early crossings are dropped under duty reduce
  assign set_on  = !minoff_i && cross_i && (!reduce_i || cnt_i >= RedPh);
  assign lim_now = lim_q || pk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      lim_q <= 1'b0;
    end else if (minoff_i) begin  // blanking clears both, overrides all
      on_q  <= 1'b0;
      lim_q <= 1'b0;
    end else begin
      on_q  <= on_q || set_on;
      lim_q <= lim_now;
    end
  end

  assign on_o   = on_q;
  assign gate_o = (on_q || set_on) && !lim_now && !fault_i && !minoff_i;

  a_r3_blank_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    minoff_i |=> (!on_q && !lim_q));
endmodule

// File: rtl/boost_pwm_gate.sv
module boost_pwm_gate #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int SW_HZ       = 65_000,
  parameter int TOFF_NS     = 250,
  parameter int DEGLITCH_NS = 300,
  parameter int REDUCE_PCT  = 50,
  localparam int Period = CLK_HZ / SW_HZ,
  localparam int CntW   = $clog2(Period)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cross_i,
  input  logic            peak_i,
  input  logic            fault_i,
  input  logic            reduce_i,
  output logic            gate_o,
  output logic [CntW-1:0] ramp_o
);
  import pwm_cfg_pkg::*;

  localparam int Toff  = ns_to_cyc(longint'(TOFF_NS), longint'(CLK_HZ));
  localparam int Dg    = ns_to_cyc(longint'(DEGLITCH_NS), longint'(CLK_HZ));
  localparam int RedAt = (Period * REDUCE_PCT) / 100;

  logic [CntW-1:0] cnt;
  logic            minoff, pk_acc, on_st;

  pwm_period_cnt #(.PERIOD(Period), .TOFF(Toff), .CNT_W(CntW)) u_cnt (
    .clk_i, .rst_ni, .cnt_o(cnt), .minoff_o(minoff), .ramp_o(ramp_o)
  );

  pwm_deglitch #(.DG(Dg)) u_dg (
    .clk_i, .rst_ni, .peak_i, .acc_o(pk_acc)
  );

  pwm_gate_ctl #(.CNT_W(CntW), .RED_AT(RedAt)) u_gate (
    .clk_i, .rst_ni, .cnt_i(cnt), .minoff_i(minoff), .cross_i, .reduce_i,
    .pk_i(pk_acc), .fault_i, .on_o(on_st), .gate_o(gate_o)
  );

  a_r10_reduce_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(on_st) && $past(reduce_i)) |-> ($past(cnt) >= CntW'(RedAt)));
  a_r7_limit_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pk_acc) && !$past(minoff) && !minoff) |-> !gate_o);
endmodule

// File: tb/boost_pwm_gate_test.sv
`timescale 1ns/1ps
module boost_pwm_gate_test;
  localparam int CLK_HZ = 200_000_000;
  localparam int SW_HZ  = 500_000;
  localparam int P      = CLK_HZ / SW_HZ;                 // 400
  localparam int TOFF   = (250 * (CLK_HZ / 1000) + 999_999) / 1_000_000; // 50
  localparam int DG     = (300 * (CLK_HZ / 1000) + 999_999) / 1_000_000; // 60
  localparam int RAT    = P * 50 / 100;                   // 200
  localparam int W      = $clog2(P);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cross_i = 0, peak_i = 0, fault_i = 0, reduce_i = 0;
  logic gate_o;
  logic [W-1:0] ramp_o;

  int errors = 0, checks = 0, on_cnt = 0;
  int m_cnt = 0, m_run = 0;
  bit m_on = 0, m_lim = 0, done = 0;

  always #2.5 clk = ~clk;

  boost_pwm_gate #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .TOFF_NS(250),
                   .DEGLITCH_NS(300), .REDUCE_PCT(50)) uut (
    .clk_i(clk), .rst_ni, .cross_i, .peak_i, .fault_i, .reduce_i,
    .gate_o, .ramp_o);

  function automatic bit exp_gate(bit cr, bit ft, bit rd);
    bit mo = m_cnt < TOFF;
    bit so = !mo && cr && (!rd || m_cnt >= RAT);
    return !mo && (m_on || so) && !(m_lim || m_run >= DG) && !ft;
  endfunction

  function automatic int exp_ramp();
    return (m_cnt < TOFF) ? 0 : m_cnt - TOFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s phase=%0d actual=%0d expected=%0d", tag, m_cnt, act, exp);
    end
  endtask

  // called just after a falling edge; drives, checks, advances model
  task automatic step(bit cr, bit pk, bit ft, bit rd, string tag);
    bit mo, so, eg;
    cross_i = cr; peak_i = pk; fault_i = ft; reduce_i = rd;
    #1;
    eg = exp_gate(cr, ft, rd);
    chk(tag, int'(gate_o), int'(eg));
    chk("R4", int'(ramp_o), exp_ramp());
    if (gate_o) on_cnt++;
    mo = m_cnt < TOFF;
    so = !mo && cr && (!rd || m_cnt >= RAT);
    if (mo) begin m_on = 0; m_lim = 0; end
    else begin m_on = m_on || so; m_lim = m_lim || (m_run >= DG); end
    m_run = pk ? ((m_run < DG) ? m_run + 1 : DG) : 0;
    m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    @(negedge clk);
  endtask

  // one full period; window bounds are phases [start,end)
  task automatic period(int c0, int c1, int p0, int p1, int f0, int f1,
                        bit rd, string tag);
    on_cnt = 0;
    for (int c = 0; c < P; c++)
      step(c >= c0 && c < c1, c >= p0 && c < p1, c >= f0 && c < f1, rd, tag);
  endtask

  initial begin
    #750_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cross_i = 1; peak_i = 0; fault_i = 0; reduce_i = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(gate_o), 0);          // R1: reset holds gate low
    chk("R1", int'(ramp_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    // R6: crossing held high -> P-TOFF on clocks
    repeat (2) begin
      period(0, P, P, P, P, P, 0, "R6");
      chk("R6", on_cnt, P - TOFF);
    end
    // R2: phase wrapped after exactly P clocks
    chk("R2", int'(ramp_o), 0);
    // R5: late crossing latched even after comparator drops
    period(180, 185, P, P, P, P, 0, "R5");
    chk("R5", on_cnt, P - 180);
    period(TOFF, TOFF + 1, P, P, P, P, 0, "R5");
    chk("R5", on_cnt, P - TOFF);
    // R3: crossing and peak only inside blanking leave no trace
    period(0, TOFF, 0, TOFF, P, P, 0, "R3");
    chk("R3", on_cnt, 0);
    // R8: peak one sample short of the filter
    period(TOFF, P, 100, 100 + DG - 1, P, P, 0, "R8");
    chk("R8", on_cnt, P - TOFF);
    // R7: peak exactly at filter length, gate off from next clock
    period(TOFF, P, 100, 100 + DG, P, P, 0, "R7");
    chk("R7", on_cnt, 100 + DG - TOFF);
    // R7: limit cleared at next period start
    period(0, P, P, P, P, P, 0, "R7");
    chk("R7", on_cnt, P - TOFF);
    // R9: fault masks, gate returns afterwards
    period(0, P, P, P, 120, 140, 0, "R9");
    chk("R9", on_cnt, P - TOFF - 20);
    // R10: early crossing ignored, held crossing starts at RAT
    period(0, P, P, P, P, P, 1, "R10");
    chk("R10", on_cnt, P - RAT);
    period(TOFF + 5, TOFF + 20, P, P, P, P, 1, "R10");
    chk("R10", on_cnt, 0);

    // random mix
    repeat (20) begin
      int c0 = $urandom_range(0, P);
      int c1 = c0 + $urandom_range(1, P);
      int p0 = ($urandom_range(0, 2) == 0) ? $urandom_range(0, P - 1) : P;
      int p1 = p0 + $urandom_range(DG - 3, DG + 3);
      int f0 = ($urandom_range(0, 3) == 0) ? $urandom_range(0, P - 1) : P;
      int f1 = f0 + $urandom_range(1, 30);
      period(c0, c1, p0, p1, f0, f1, 1'($urandom_range(0, 1)), "R5");
    end
    chk("R2", int'(ramp_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule